// File: doc/BRIEF.md
# ECC Parity to Spare-Area Byte Packer

After a hardware ECC engine has finished a 512-byte sector, this block takes the engine's raw parity words. It reorders their bits into spare-area code bytes. It then emits those bytes as a short burst of byte writes, each one carrying the spare-buffer offset where the byte belongs. The controller that drives page programming pulses `start` once per sector. With that pulse it supplies the parity words, the correction strength, the page size and the sector number. The byte-write port then feeds the spare buffer directly.

There are two correction strengths. The single-bit scheme keeps two 12-bit fields of the first parity word and joins them into a 24-bit code. It inverts that code so that an erased, all-ones sector carries a matching code, and writes it as three bytes. The four-bit scheme takes eight 10-bit syndromes from four parity words and packs them tightly into ten bytes. Byte placement depends on the page size. On small pages, the four-bit layout steps around the factory bad-block marker byte and a reserved gap.

Top module: `ecc_spare_packer`

## Requirements
- R1: In single-bit mode (`ecc_mode`=0), the code is formed as follows. Take bits 27:16 of parity word 0 (bits 31:0 of `parity`) as the upper 12 bits. Take bits 11:0 as the lower 12 bits. Invert all 24 bits. The result is written as three bytes, bits 7:0 first, then 15:8, then 23:16.
- R2: In single-bit mode, the three bytes go to consecutive offsets. The first offset is base + 3 × `sector`. The base is 0, 40 or 80 for `page_sel` = 0 (512-byte page), 1 (2048) and 2 (4096).
- R3: In four-bit mode (`ecc_mode`=1), the syndromes come from words w0..w3, where word i is `parity[32i+31:32i]`. Words (w0,w1) form the first pair and (w2,w3) the second. For each pair p0,p1, five bytes are written in this order: p0[7:0]; {p0[21:16], p0[9:8]}; {p1[3:0], p0[25:22]}; {p1[17:16], p1[9:4]}; p1[25:18].
- R4: In four-bit mode on a 512-byte page, the ten bytes go to offsets 0,1,2,3,4,6,7,13,14,15, in that order. Offsets 5 and 8–12 are never written.
- R5: In four-bit mode on 2048-byte and 4096-byte pages, byte k of sector s goes to offset 24 + 10s + k or 48 + 10s + k respectively.
- R6: An accepted `start` produces exactly 3 (single-bit) or 10 (four-bit) writes. They fall in consecutive cycles, one byte per cycle. The first write is visible in the cycle after the second rising edge following the `start` cycle, i.e. one cycle after the capture edge.
- R7: `done` is high for exactly one cycle, in the cycle right after the last write of a sector, and `wr_en` is low in that cycle.
- R8: A `start` while `busy` is high is ignored. The running sector's bytes and offsets are not changed, and no extra writes follow.
- R9: A `start` is ignored in three cases: `page_sel`=3, a nonzero `sector` on a 512-byte page, or `sector` ≥ 4 on a 2048-byte page. No write and no `done` follow.
- R10: While and right after synchronous reset, `wr_en`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: capture parity and sector context |
| ecc_mode | input | 1 | 0 = single-bit code, 1 = four-bit code |
| page_sel | input | 2 | 0 = 512, 1 = 2048, 2 = 4096-byte page |
| sector | input | 3 | Sector number within the page |
| parity | input | 128 | Four raw 32-bit parity words, word 0 in bits 31:0 |
| busy | output | 1 | A sector's bytes are being emitted |
| wr_en | output | 1 | Byte write strobe to the spare buffer |
| wr_off | output | 7 | Spare-buffer byte offset |
| wr_data | output | 8 | Code byte |
| done | output | 1 | One-cycle pulse after a sector's last byte |

## Verification
The `start` inputs are captured at one rising edge. The first byte-write is registered at the next edge, and the remaining bytes follow one per edge. `done` rises one edge after the last write. The bench drives stimulus on the falling edge and samples 1 ns after each rising edge. It counts edges from the capture edge, so write k is checked after capture edge + k + 1, and `done` is checked at the edge after that. One further cycle is checked for silence. Ignored starts are judged by watching four cycles of `wr_en` and `done` after the pulse, and by comparing an overlapped burst against the first sector's expected bytes.

// File: rtl/ecc_pack_pkg.sv
package ecc_pack_pkg;
  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 4;
  localparam int CODE_BYTES  = 10;
  localparam int ONE_BYTES   = 3;
  localparam int OFF_W       = 7;
  localparam int SEC_W       = 3;
  localparam int CNT_W       = $clog2(CODE_BYTES + 1);

  // page size encodings
  localparam logic [1:0] PG_SMALL = 2'd0;
  localparam logic [1:0] PG_MID   = 2'd1;
  localparam logic [1:0] PG_LARGE = 2'd2;

  // single-bit code bases
  localparam int ONE_BASE_MID   = 40;
  localparam int ONE_BASE_LARGE = 80;
  // four-bit code bases
  localparam int QUAD_BASE_MID   = 24;
  localparam int QUAD_BASE_LARGE = 48;

  function automatic logic [SEC_W:0] sectors_in_page(input logic [1:0] pg);
    case (pg)
      PG_SMALL: return (SEC_W+1)'(1);
      PG_MID:   return (SEC_W+1)'(4);
      PG_LARGE: return (SEC_W+1)'(8);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/ecc_code_packer.sv
module ecc_code_packer
  import ecc_pack_pkg::*;
#(
  parameter int W_W = WORD_W,
  parameter int N_W = NUM_WORDS,
  parameter int N_B = CODE_BYTES
) (
  input  logic                 mode4,
  input  logic [N_W*W_W-1:0]   parity,
  output logic [N_B*8-1:0]     code,
  output logic [CNT_W-1:0]     nbytes
);
  localparam int PAIRS = N_W / 2;

  logic [PAIRS*40-1:0] quad;
  logic [23:0]         one_raw;

  generate
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
      logic [W_W-1:0] p0, p1;
      assign p0 = parity[(2*g)*W_W +: W_W];
      assign p1 = parity[(2*g+1)*W_W +: W_W];
      assign quad[g*40 +: 40] = {
        p1[25:18],
        p1[17:16], p1[9:4],
        p1[3:0],   p0[25:22],
        p0[21:16], p0[9:8],
        p0[7:0]
      };
    end
  endgenerate

  assign one_raw = {parity[27:16], parity[11:0]};

  always_comb begin
    if (mode4) begin
      code   = quad;
      nbytes = CNT_W'(N_B);
    end else begin
      code   = {{(N_B*8-24){1'b1}}, ~one_raw};
      nbytes = CNT_W'(ONE_BYTES);
    end
  end
endmodule

// File: rtl/ecc_spare_locator.sv
module ecc_spare_locator
  import ecc_pack_pkg::*;
(
  input  logic             mode4,
  input  logic [1:0]       page,
  input  logic [SEC_W-1:0] sec,
  input  logic [CNT_W-1:0] idx,
  output logic [OFF_W-1:0] off
);
  logic [OFF_W:0] lin;
  logic [OFF_W:0] base;

  always_comb begin
    base = '0;
    lin  = '0;
    if (!mode4) begin
      case (page)
        PG_MID:   base = (OFF_W+1)'(ONE_BASE_MID);
        PG_LARGE: base = (OFF_W+1)'(ONE_BASE_LARGE);
        default:  base = '0;
      endcase
      lin = base + (OFF_W+1)'(sec) * (OFF_W+1)'(ONE_BYTES) + (OFF_W+1)'(idx);
    end else begin
      case (page)
        PG_SMALL: begin
          // step over the marker byte and the reserved gap
          if (idx < CNT_W'(5))      lin = (OFF_W+1)'(idx);
          else if (idx < CNT_W'(7)) lin = (OFF_W+1)'(idx) + 1'b1;
          else                      lin = (OFF_W+1)'(idx) + (OFF_W+1)'(6);
        end
        PG_MID:
          lin = (OFF_W+1)'(QUAD_BASE_MID) + (OFF_W+1)'(sec) * (OFF_W+1)'(CODE_BYTES)
              + (OFF_W+1)'(idx);
        default:
          lin = (OFF_W+1)'(QUAD_BASE_LARGE) + (OFF_W+1)'(sec) * (OFF_W+1)'(CODE_BYTES)
              + (OFF_W+1)'(idx);
      endcase
    end
    off = lin[OFF_W-1:0];
  end
endmodule

// File: rtl/ecc_spare_packer.sv
module ecc_spare_packer
  import ecc_pack_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        ecc_mode,
  input  logic [1:0]                  page_sel,
  input  logic [SEC_W-1:0]            sector,
  input  logic [NUM_WORDS*WORD_W-1:0] parity,
  output logic                        busy,
  output logic                        wr_en,
  output logic [OFF_W-1:0]            wr_off,
  output logic [7:0]                  wr_data,
  output logic                        done
);
  logic [CODE_BYTES*8-1:0] code_c;
  logic [CNT_W-1:0]        nb_c;

  logic [CODE_BYTES*8-1:0] code_q;
  logic [CNT_W-1:0]        nb_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    mode_q;
  logic [1:0]              page_q;
  logic [SEC_W-1:0]        sec_q;
  logic                    active_q;
  logic                    last_q;
  logic                    wr_en_q;
  logic [OFF_W-1:0]        wr_off_q;
  logic [7:0]              wr_data_q;
  logic                    done_q;
  logic [OFF_W-1:0]        loc_off;
  logic                    ctx_ok;
  logic                    is_last;

  ecc_code_packer i_pack (
    .mode4  (ecc_mode),
    .parity (parity),
    .code   (code_c),
    .nbytes (nb_c)
  );

  ecc_spare_locator i_loc (
    .mode4 (mode_q),
    .page  (page_q),
    .sec   (sec_q),
    .idx   (cnt_q),
    .off   (loc_off)
  );

  assign ctx_ok  = ({1'b0, sector} < sectors_in_page(page_sel));
  assign is_last = (cnt_q == nb_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      wr_en_q  <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q  <= wr_en_q & last_q;
      wr_en_q <= active_q;
      if (active_q) begin
        wr_off_q  <= loc_off;
        wr_data_q <= code_q[cnt_q*8 +: 8];
        last_q    <= is_last;
        cnt_q     <= cnt_q + 1'b1;
        if (is_last) active_q <= 1'b0;
      end else begin
        last_q <= 1'b0;
        if (start && ctx_ok) begin
          code_q   <= code_c;
          nb_q     <= nb_c;
          mode_q   <= ecc_mode;
          page_q   <= page_sel;
          sec_q    <= sector;
          cnt_q    <= '0;
          active_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = active_q;
  assign wr_en   = wr_en_q;
  assign wr_off  = wr_off_q;
  assign wr_data = wr_data_q;
  assign done    = done_q;

  // R10
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!wr_en && !done && !busy));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!wr_en && $past(wr_en)));

  // R6
  offset_rising_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && !$past(done) && !$past(last_q)) |-> (wr_off > $past(wr_off)));

  // R4
  marker_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode_q && page_q == PG_SMALL) |-> (wr_off != 7'd5 && (wr_off < 7'd8 || wr_off > 7'd12)));

  // R8
  busy_holds_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(sec_q) && $stable(mode_q) && $stable(page_q)));
endmodule

// File: tb/test_ecc_spare_packer.sv
module test_ecc_spare_packer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         ecc_mode = 1'b0;
  logic [1:0]   page_sel = 2'd0;
  logic [2:0]   sector = 3'd0;
  logic [127:0] parity = '0;
  logic         busy, wr_en, done;
  logic [6:0]   wr_off;
  logic [7:0]   wr_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ecc_spare_packer i_ecc_spare_packer (
    .clk(clk), .rst(rst), .start(start), .ecc_mode(ecc_mode),
    .page_sel(page_sel), .sector(sector), .parity(parity),
    .busy(busy), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit m4, input logic [127:0] par, input int k);
    logic [31:0] w, v, p0, p1;
    int j, r;
    if (!m4) begin
      w = par[31:0];
      v = (w & 32'h0000_0fff) | ((w & 32'h0fff_0000) >> 4);
      v = ~v;
      return 8'(v >> (8 * k));
    end
    j  = k / 5;
    r  = k % 5;
    p0 = par[64*j +: 32] & 32'h03ff_03ff;
    p1 = par[64*j+32 +: 32] & 32'h03ff_03ff;
    case (r)
      0: return 8'(p0 & 32'hff);
      1: return 8'(((p0 >> 8) & 32'h03) | ((p0 >> 14) & 32'hfc));
      2: return 8'(((p0 >> 22) & 32'h0f) | ((p1 << 4) & 32'hf0));
      3: return 8'(((p1 >> 4) & 32'h3f) | ((p1 >> 10) & 32'hc0));
      default: return 8'((p1 >> 18) & 32'hff);
    endcase
  endfunction

  function automatic int exp_off(input bit m4, input logic [1:0] pg, input int sec, input int k);
    int small_map [10] = '{0, 1, 2, 3, 4, 6, 7, 13, 14, 15};
    if (!m4) return (pg == 2'd0 ? 0 : pg == 2'd1 ? 40 : 80) + 3 * sec + k;
    if (pg == 2'd0) return small_map[k];
    return (pg == 2'd1 ? 24 : 48) + 10 * sec + k;
  endfunction

  task automatic do_sector(input bit m4, input logic [1:0] pg, input logic [2:0] sec,
                           input logic [127:0] par, input bit intrude);
    int n = m4 ? 10 : 3;
    string otag = !m4 ? "R2" : (pg == 2'd0 ? "R4" : "R5");
    string dtag = m4 ? "R3" : "R1";
    @(negedge clk);
    ecc_mode = m4; page_sel = pg; sector = sec; parity = par; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(!wr_en, "R6", "no write in capture cycle", wr_en, 0);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (intrude && k == 0) begin
        start = 1'b1; parity = ~par; sector = 3'd0; page_sel = 2'd1;
      end
      if (intrude && k == 1) start = 1'b0;
      chk(wr_en, "R6", "write strobe", wr_en, 1);
      chk(int'(wr_off) == exp_off(m4, pg, sec, k), intrude ? "R8" : otag, "offset",
          wr_off, exp_off(m4, pg, sec, k));
      chk(wr_data == exp_byte(m4, par, k), intrude ? "R8" : dtag, "byte",
          wr_data, exp_byte(m4, par, k));
    end
    @(posedge clk); #1;
    chk(done && !wr_en, "R7", "done after last write", {wr_en, done}, 1);
    @(posedge clk); #1;
    chk(!done && !wr_en, intrude ? "R8" : "R7", "quiet after done", {wr_en, done}, 0);
  endtask

  task automatic bad_start(input logic [1:0] pg, input logic [2:0] sec);
    bit seen = 1'b0;
    @(negedge clk);
    ecc_mode = 1'b1; page_sel = pg; sector = sec; parity = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      if (wr_en || done || busy) seen = 1'b1;
    end
    chk(!seen, "R9", "ignored start activity", seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(!wr_en && !done && !busy, "R10", "outputs in reset", {busy, wr_en, done}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(!wr_en && !done && !busy, "R10", "outputs after reset", {busy, wr_en, done}, 0);

    // directed corners
    do_sector(1'b0, 2'd0, 3'd0, '0, 1'b0);                          // R1 all-zero
    do_sector(1'b0, 2'd2, 3'd7, 128'h0000_0000_0000_0000_0000_0000_f5a3_c96e, 1'b0); // R2
    do_sector(1'b1, 2'd0, 3'd0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 1'b0); // R4
    do_sector(1'b1, 2'd1, 3'd3, '1, 1'b0);                          // R5 top of 2K
    do_sector(1'b1, 2'd2, 3'd7, 128'h1357_9bdf_2468_ace0_0f0f_f0f0_aaaa_5555, 1'b0); // R5
    do_sector(1'b0, 2'd1, 3'd2, 128'h0000_0000_0000_0000_0000_0000_0abc_0def, 1'b1); // R8
    do_sector(1'b1, 2'd2, 3'd1, 128'hdead_beef_cafe_f00d_1234_5678_9abc_def0, 1'b1); // R8
    bad_start(2'd3, 3'd0);   // R9
    bad_start(2'd0, 3'd1);   // R9
    bad_start(2'd1, 3'd4);   // R9

    // constrained random sectors
    for (int i = 0; i < 40; i++) begin
      bit m4 = 1'($urandom);
      logic [1:0] pg = 2'($urandom_range(0, 2));
      logic [2:0] sec = (pg == 2'd0) ? 3'd0 : (pg == 2'd1) ? 3'($urandom_range(0, 3))
                                                         : 3'($urandom_range(0, 7));
      logic [127:0] par = {$urandom, $urandom, $urandom, $urandom};
      do_sector(m4, pg, sec, par, 1'b0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule